// File: doc/BRIEF.md
# Card Window Address Decoder

This block holds the address windows of a two-slot card bus controller and tells the access engine, for each host access, which window the address falls in and how that window is set up. Each window is a pair of 32-bit words, a base word and an option word, written and read back over a simple register port. The option word packs the window's size, enable, write protection, target slot, address space, port width and three access timing fields.

A host access is offered on the lookup port for one cycle. It is compared with every enabled window at once, and the lowest-numbered matching window is chosen. One cycle later the block presents that window's index and attributes. It also presents either a cycle-start pulse for the access engine or, when a write lands in a protected window, a one-cycle error pulse. Window sizes come from a 5-bit code whose values are not in size order, and some code values are illegal.

Top module: `card_window_decoder`

## Requirements
- R1: Register word `2*w` is the base of window `w` and word `2*w+1` is its option; a write on the register port updates that word on the next clock edge, and `reg_rd_data` returns the addressed word combinationally.
- R2: Synchronous active-high reset clears every base and option word and every result output.
- R3: Window `w` matches address `a` when its option bit 0 (enable) is 1, its size code is legal, and `a` and the base agree in every bit at or above log2(size).
- R4: The size code sits in option bits 31:27. Codes 0..15 give sizes 1, 2, 8, 4, 128, 64, 16, 32, 32K, 16K, 4K, 8K, 256, 512, 2K and 1K bytes in that code order. Code 20 gives 16M, 21 gives 32M and 23 gives 64M. Codes 24..31 give 64K, 128K, 512K, 256K, 8M, 4M, 1M and 2M in that code order.
- R5: A window whose size code is 16, 17, 18, 19 or 22 never matches.
- R6: A window whose option word is zero never matches, whatever its base.
- R7: When several windows match, the result reports the lowest window index.
- R8: On a hit, `res_wp` = option bit 1, `res_slot` = option bit 2 (0 = slot A, 1 = slot B), `res_space` = option bits 4:3 (00 common memory, 10 attribute memory, 11 I/O) and `res_wide` = option bit 6 (16-bit port).
- R9: On a hit, `res_strobe` = option bits 11:7, `res_setup` = option bits 15:12 and `res_hold` = option bits 19:16.
- R10: A write that hits a write-protected window gives `wp_err` high for exactly that result cycle and no `cycle_start`. A read of that window, or a write to an unprotected window, gives `cycle_start` and no `wp_err`.
- R11: Results appear on the cycle after `acc_valid`, with `res_valid` high. On a miss, `res_hit`, `cycle_start`, `wp_err` and all attribute outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register word select for write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register word select for read |
| reg_rd_data | output | 32 | Register read data |
| acc_valid | input | 1 | Host access offered this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Host access address |
| res_valid | output | 1 | Result for the previous cycle's access |
| res_hit | output | 1 | Some window matched |
| res_win | output | 3 | Index of the chosen window |
| res_slot | output | 1 | Target slot |
| res_space | output | 2 | Address space code |
| res_wide | output | 1 | 16-bit port |
| res_wp | output | 1 | Window is write-protected |
| res_strobe | output | 5 | Strobe length field |
| res_setup | output | 4 | Setup field |
| res_hold | output | 4 | Hold field |
| cycle_start | output | 1 | Start a card cycle |
| wp_err | output | 1 | Write to protected window |

## Verification
Assertions check on every cycle that the priority grant is one-hot and that no matching window lies below it. They also check that a zero option word never produces a match, that option writes land in storage, that an error pulse is never paired with a cycle start and always follows a write, and that a cycle start always comes with a hit. Only the bench scenarios can show that the scrambled size table gives the right window boundaries, one size code at a time. The same holds for the packed attribute fields reaching the correct outputs and for overlapping windows resolving to the right index.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SIZE_W   = 5;
    localparam int unsigned LG_W     = 5;

    typedef enum logic [1:0] {
        SPACE_COMMON = 2'b00,
        SPACE_RSVD   = 2'b01,
        SPACE_ATTR   = 2'b10,
        SPACE_IO     = 2'b11
    } space_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size_code;  // 31:27
        logic [6:0]        spare_hi;   // 26:20
        logic [3:0]        hold;       // 19:16
        logic [3:0]        setup;      // 15:12
        logic [4:0]        strobe;     // 11:7
        logic              wide;       // 6
        logic              spare_lo;   // 5
        space_e            space;      // 4:3
        logic              slot;       // 2
        logic              wp;         // 1
        logic              enable;     // 0
    } opt_word_t;

    typedef struct packed {
        logic            legal;
        logic [LG_W-1:0] lg;
    } size_info_t;

    typedef struct packed {
        logic       slot;
        space_e     space;
        logic       wide;
        logic       wp;
        logic [4:0] strobe;
        logic [3:0] setup;
        logic [3:0] hold;
    } win_attr_t;

    function automatic size_info_t decode_size(input logic [SIZE_W-1:0] code);
        size_info_t r;
        r.legal = 1'b1;
        unique case (code)
            5'd0:  r.lg = 5'd0;
            5'd1:  r.lg = 5'd1;
            5'd2:  r.lg = 5'd3;
            5'd3:  r.lg = 5'd2;
            5'd4:  r.lg = 5'd7;
            5'd5:  r.lg = 5'd6;
            5'd6:  r.lg = 5'd4;
            5'd7:  r.lg = 5'd5;
            5'd8:  r.lg = 5'd15;
            5'd9:  r.lg = 5'd14;
            5'd10: r.lg = 5'd12;
            5'd11: r.lg = 5'd13;
            5'd12: r.lg = 5'd8;
            5'd13: r.lg = 5'd9;
            5'd14: r.lg = 5'd11;
            5'd15: r.lg = 5'd10;
            5'd20: r.lg = 5'd24;
            5'd21: r.lg = 5'd25;
            5'd23: r.lg = 5'd26;
            5'd24: r.lg = 5'd16;
            5'd25: r.lg = 5'd17;
            5'd26: r.lg = 5'd19;
            5'd27: r.lg = 5'd18;
            5'd28: r.lg = 5'd23;
            5'd29: r.lg = 5'd22;
            5'd30: r.lg = 5'd20;
            5'd31: r.lg = 5'd21;
            default: begin
                r.legal = 1'b0;
                r.lg    = 5'd0;
            end
        endcase
        return r;
    endfunction

    function automatic win_attr_t attr_of(input opt_word_t o);
        win_attr_t a;
        a.slot   = o.slot;
        a.space  = o.space;
        a.wide   = o.wide;
        a.wp     = o.wp;
        a.strobe = o.strobe;
        a.setup  = o.setup;
        a.hold   = o.hold;
        return a;
    endfunction

endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile
    import cwd_pkg::*;
#(
    parameter int unsigned NUM_WIN = 8,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [$clog2(2*NUM_WIN)-1:0]      wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [$clog2(2*NUM_WIN)-1:0]      rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [NUM_WIN-1:0][DATA_W-1:0]    base_q,
    output logic [NUM_WIN-1:0][DATA_W-1:0]    opt_q
);
    localparam int unsigned RA_W  = $clog2(2*NUM_WIN);
    localparam int unsigned IDX_W = RA_W - 1;

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    assign wr_idx = wr_addr[RA_W-1:1];
    assign rd_idx = rd_addr[RA_W-1:1];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[w] <= '0;
                opt_q[w]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(w))) begin
                if (wr_addr[0]) opt_q[w]  <= wr_data;
                else            base_q[w] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = rd_addr[0] ? opt_q[rd_idx] : base_q[rd_idx];
    end

    // R1: an option write is visible in storage on the next cycle
    a_r1_opt_written: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[0]) |=> (opt_q[$past(wr_idx)] == $past(wr_data)));

    // R1: a base write is visible in storage on the next cycle
    a_r1_base_written: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr[0]) |=> (base_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/cwd_win_match.sv
module cwd_win_match
    import cwd_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] opt,
    output logic              match
);
    opt_word_t         o;
    size_info_t        si;
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] diff;

    always_comb begin
        o         = opt_word_t'(opt);
        si        = decode_size(o.size_code);
        keep_mask = {ADDR_W{1'b1}} << si.lg;
        diff      = (addr ^ base[ADDR_W-1:0]) & keep_mask;
        match     = o.enable && si.legal && (diff == '0);
    end

endmodule

// File: rtl/cwd_prio.sv
module cwd_prio #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx   = $clog2(N)'(i);
                any   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/card_window_decoder.sv
module card_window_decoder
    import cwd_pkg::*;
#(
    parameter int unsigned NUM_WIN = 8,
    parameter int unsigned ADDR_W  = 32,
    localparam int unsigned RA_W   = $clog2(2*NUM_WIN),
    localparam int unsigned IDX_W  = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [RA_W-1:0]   reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic [RA_W-1:0]   reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_win,
    output logic              res_slot,
    output logic [1:0]        res_space,
    output logic              res_wide,
    output logic              res_wp,
    output logic [4:0]        res_strobe,
    output logic [3:0]        res_setup,
    output logic [3:0]        res_hold,
    output logic              cycle_start,
    output logic              wp_err
);
    logic [NUM_WIN-1:0][WORD_W-1:0] base_q;
    logic [NUM_WIN-1:0][WORD_W-1:0] opt_q;
    logic [NUM_WIN-1:0]             match;
    logic [NUM_WIN-1:0]             grant;
    logic [IDX_W-1:0]               sel_idx;
    logic                           any_hit;
    win_attr_t                      sel_attr;
    logic                           blocked;

    cwd_regfile #(.NUM_WIN(NUM_WIN), .DATA_W(WORD_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .base_q  (base_q),
        .opt_q   (opt_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        cwd_win_match #(.ADDR_W(ADDR_W)) u_match (
            .addr  (acc_addr),
            .base  (base_q[w]),
            .opt   (opt_q[w]),
            .match (match[w])
        );

        // R6: a cleared option word never produces a match
        a_r6_zero_opt_idle: assert property (@(posedge clk) disable iff (rst)
            (opt_q[w] == '0) |-> !match[w]);
    end

    cwd_prio #(.N(NUM_WIN)) u_prio (
        .req   (match),
        .grant (grant),
        .idx   (sel_idx),
        .any   (any_hit)
    );

    always_comb begin
        sel_attr = attr_of(opt_word_t'(opt_q[sel_idx]));
        blocked  = acc_write && sel_attr.wp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_hit     <= 1'b0;
            res_win     <= '0;
            res_slot    <= 1'b0;
            res_space   <= 2'b00;
            res_wide    <= 1'b0;
            res_wp      <= 1'b0;
            res_strobe  <= '0;
            res_setup   <= '0;
            res_hold    <= '0;
            cycle_start <= 1'b0;
            wp_err      <= 1'b0;
        end else begin
            res_valid   <= acc_valid;
            res_hit     <= acc_valid && any_hit;
            cycle_start <= acc_valid && any_hit && !blocked;
            wp_err      <= acc_valid && any_hit && blocked;
            if (acc_valid && any_hit) begin
                res_win    <= sel_idx;
                res_slot   <= sel_attr.slot;
                res_space  <= sel_attr.space;
                res_wide   <= sel_attr.wide;
                res_wp     <= sel_attr.wp;
                res_strobe <= sel_attr.strobe;
                res_setup  <= sel_attr.setup;
                res_hold   <= sel_attr.hold;
            end else begin
                res_win    <= '0;
                res_slot   <= 1'b0;
                res_space  <= 2'b00;
                res_wide   <= 1'b0;
                res_wp     <= 1'b0;
                res_strobe <= '0;
                res_setup  <= '0;
                res_hold   <= '0;
            end
        end
    end

    // R7: at most one window is granted
    a_r7_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R7: no matching window sits below the granted one
    a_r7_grant_lowest: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> (((grant - NUM_WIN'(1)) & match) == '0));

    // R10: an error pulse never comes with a cycle start
    a_r10_err_excl_start: assert property (@(posedge clk) disable iff (rst)
        !(wp_err && cycle_start));

    // R10: an error pulse only follows a write access
    a_r10_err_after_write: assert property (@(posedge clk) disable iff (rst)
        wp_err |-> $past(acc_valid && acc_write));

    // R11: a cycle start implies a reported hit
    a_r11_start_has_hit: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> (res_hit && res_valid));

    // R2: results are quiet on the first cycle out of reset
    a_r2_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!res_hit && !wp_err && !cycle_start));

endmodule

// File: tb/tb_card_window_decoder.sv
module tb_card_window_decoder;

    localparam time PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [3:0]  reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic [3:0]  reg_rd_addr;
    logic [31:0] reg_rd_data;
    logic        acc_valid;
    logic        acc_write;
    logic [31:0] acc_addr;
    logic        res_valid;
    logic        res_hit;
    logic [2:0]  res_win;
    logic        res_slot;
    logic [1:0]  res_space;
    logic        res_wide;
    logic        res_wp;
    logic [4:0]  res_strobe;
    logic [3:0]  res_setup;
    logic [3:0]  res_hold;
    logic        cycle_start;
    logic        wp_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    card_window_decoder dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_win(res_win),
        .res_slot(res_slot), .res_space(res_space), .res_wide(res_wide),
        .res_wp(res_wp), .res_strobe(res_strobe), .res_setup(res_setup),
        .res_hold(res_hold), .cycle_start(cycle_start), .wp_err(wp_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic w);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w;
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    // log2 of window size for each size code; -1 marks illegal codes
    function automatic int size_lg(input int code);
        case (code)
            0: return 0;   1: return 1;   2: return 3;   3: return 2;
            4: return 7;   5: return 6;   6: return 4;   7: return 5;
            8: return 15;  9: return 14;  10: return 12; 11: return 13;
            12: return 8;  13: return 9;  14: return 11; 15: return 10;
            20: return 24; 21: return 25; 23: return 26;
            24: return 16; 25: return 17; 26: return 19; 27: return 18;
            28: return 23; 29: return 22; 30: return 20; 31: return 21;
            default: return -1;
        endcase
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] base;
        logic [31:0] opt;
        rst = 1'b1; reg_wr_en = 0; reg_wr_addr = 0; reg_wr_data = 0;
        reg_rd_addr = 0; acc_valid = 0; acc_write = 0; acc_addr = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2: all registers read back zero after reset
        for (int i = 0; i < 16; i++) begin
            reg_rd_addr = 4'(i); #1;
            chk($sformatf("R2 reg %0d after reset", i), reg_rd_data, 32'h0);
        end
        access(32'h0, 1'b0);
        chk("R2 no hit after reset", {31'b0, res_hit}, 32'h0);
        chk("R11 res_valid on access", {31'b0, res_valid}, 32'h1);

        // R3/R4/R5: sweep every size code on window 0
        base = 32'h4000_0000;
        wr(4'd0, base);
        for (int c = 0; c < 32; c++) begin
            int lg;
            lg  = size_lg(c);
            opt = (32'(c) << 27) | 32'h1;
            wr(4'd1, opt);
            if (lg < 0) begin
                access(base, 1'b0);
                chk($sformatf("R5 illegal code %0d base", c), {31'b0, res_hit}, 32'h0);
                access(base + 32'h10, 1'b0);
                chk($sformatf("R5 illegal code %0d inside", c), {31'b0, res_hit}, 32'h0);
            end else begin
                logic [31:0] sz;
                sz = 32'h1 << lg;
                access(base + sz - 32'h1, 1'b0);
                chk($sformatf("R4 code %0d top byte hit", c), {31'b0, res_hit}, 32'h1);
                chk($sformatf("R3 code %0d start", c), {31'b0, cycle_start}, 32'h1);
                access(base + sz, 1'b0);
                chk($sformatf("R4 code %0d just above", c), {31'b0, res_hit}, 32'h0);
                access(base - 32'h1, 1'b0);
                chk($sformatf("R3 code %0d just below", c), {31'b0, res_hit}, 32'h0);
            end
        end

        // R1: option readback; R6: clearing option disables window
        reg_rd_addr = 4'd1; #1;
        chk("R1 option readback", reg_rd_data, (32'd31 << 27) | 32'h1);
        reg_rd_addr = 4'd0; #1;
        chk("R1 base readback", reg_rd_data, base);
        wr(4'd1, 32'h0);
        access(base, 1'b0);
        chk("R6 zero option no hit", {31'b0, res_hit}, 32'h0);
        chk("R11 miss no start", {31'b0, cycle_start}, 32'h0);

        // R7: overlapping windows 2 and 5 (and 7)
        wr(4'd4, 32'h1000_0000);  wr(4'd5, (32'd20 << 27) | 32'h1);
        wr(4'd10, 32'h1000_0000); wr(4'd11, (32'd0 << 27) | 32'h1);
        wr(4'd14, 32'h1000_0000); wr(4'd15, (32'd23 << 27) | 32'h1);
        access(32'h1000_0000, 1'b0);
        chk("R7 lowest of 2,5,7", {29'b0, res_win}, 32'd2);
        wr(4'd5, 32'h0);
        access(32'h1000_0000, 1'b0);
        chk("R7 lowest of 5,7", {29'b0, res_win}, 32'd5);
        access(32'h1000_0004, 1'b0);
        chk("R7 only 7 covers", {29'b0, res_win}, 32'd7);
        wr(4'd11, 32'h0); wr(4'd15, 32'h0);

        // R8/R9: attribute fields on window 3
        opt = (32'd8 << 27) | (32'd6 << 16) | (32'd9 << 12) | (32'd21 << 7)
            | (32'd1 << 6) | (32'd2 << 3) | (32'd1 << 2) | 32'h1;
        wr(4'd6, 32'h2000_0000); wr(4'd7, opt);
        access(32'h2000_7FF0, 1'b1);
        chk("R8 win index", {29'b0, res_win}, 32'd3);
        chk("R8 slot B", {31'b0, res_slot}, 32'h1);
        chk("R8 attribute space", {30'b0, res_space}, 32'h2);
        chk("R8 wide port", {31'b0, res_wide}, 32'h1);
        chk("R8 not protected", {31'b0, res_wp}, 32'h0);
        chk("R9 strobe", {27'b0, res_strobe}, 32'd21);
        chk("R9 setup", {28'b0, res_setup}, 32'd9);
        chk("R9 hold", {28'b0, res_hold}, 32'd6);
        chk("R10 write unprotected starts", {31'b0, cycle_start}, 32'h1);

        // R10: protected I/O window 4
        opt = (32'd24 << 27) | (32'd3 << 3) | 32'h3;
        wr(4'd8, 32'h3000_0000); wr(4'd9, opt);
        access(32'h3000_1234, 1'b1);
        chk("R10 wp_err on write", {31'b0, wp_err}, 32'h1);
        chk("R10 no start on blocked write", {31'b0, cycle_start}, 32'h0);
        chk("R8 io space", {30'b0, res_space}, 32'h3);
        chk("R8 wp flag", {31'b0, res_wp}, 32'h1);
        @(posedge clk); #1;
        chk("R10 pulse one cycle", {31'b0, wp_err}, 32'h0);
        chk("R11 idle res_valid low", {31'b0, res_valid}, 32'h0);
        access(32'h3000_1234, 1'b0);
        chk("R10 read protected starts", {31'b0, cycle_start}, 32'h1);
        chk("R10 read no err", {31'b0, wp_err}, 32'h0);

        // R11: miss clears attributes
        access(32'h7000_0000, 1'b1);
        chk("R11 miss hit low", {31'b0, res_hit}, 32'h0);
        chk("R11 miss attrs zero", {17'b0, res_win, res_slot, res_space, res_wide,
                                    res_wp, res_strobe}, 32'h0);
        chk("R11 miss no err", {31'b0, wp_err}, 32'h0);

        // R2: reset mid-run clears stored windows
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        reg_rd_addr = 4'd7; #1;
        chk("R2 option cleared by reset", reg_rd_data, 32'h0);
        access(32'h2000_0000, 1'b0);
        chk("R2 no hit after second reset", {31'b0, res_hit}, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule